// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This controller lets a synchronous design read and write an external asynchronous static RAM of 32768 words by 8 bits. The user side issues a single request with a read/write flag, a 15-bit address and 8-bit write data. The controller answers with a one-cycle completion pulse and, for reads, the captured byte. On the memory side it drives the address bus, three active-low strobes (chip select, output enable and write strobe) and a shared 8-bit data bus.

The length of each phase is a whole number of clock cycles. It is computed at elaboration from the clock period and the memory's minimum timings, always rounding up. A write opens with a setup cycle and then holds the write strobe low for the required number of cycles. A closing hold cycle follows, so that address and data stay stable past the edge that ends the write. A read keeps output enable low for the access time and captures the bus on the last edge of that phase. The controller drives the data bus only while output enable is high. At least one cycle with output enable high always separates a read from a following write.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and after reset, chip select, write strobe and output enable are all high (inactive) and `done` is low.
- R2: A byte written to an address is returned by a later read of that address, including at address 0 and at address 0x7FFF.
- R3: During a write, the write strobe stays low for exactly WE_CYC consecutive cycles. WE_CYC is the largest of ceil(T_AW/CLK), ceil(T_DS/CLK), ceil(T_WC/CLK)-2 and 1. That low window lasts at least T_AW_NS.
- R4: Output enable stays high for the whole of a write, and chip select stays low from the setup cycle through the hold cycle.
- R5: The memory address equals the requested address from the first cycle of the access until `done`. Write data does not change in the cycle after the write strobe rises.
- R6: During a read, output enable and chip select are low and the write strobe is high for RD_CYC cycles. RD_CYC is the larger of ceil(T_AA/CLK) and ceil(T_OE/CLK). `rdata` holds the byte sampled on the last edge of that phase.
- R7: The controller drives the data bus only in cycles where output enable is high and was also high in the previous cycle.
- R8: `done` is high for exactly one cycle per request. For a write it rises on the (WE_CYC+2)th rising edge after the accepting edge. For a read it rises on the RD_CYC-th rising edge after the accepting edge.
- R9: A request raised while an access is in progress is ignored: it produces no extra `done` and no memory change.
- R10: Between accesses chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe, sampled only while idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| rdata | output | 8 | Data from the last read |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 15 | Address to the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq | inout | 8 | Shared data bus |

## Verification
The embedded assertions are checked on every cycle. They cover bus ownership (the controller drives only with output enable high in two consecutive cycles), strobe exclusivity during reads and writes, address and data stability across the rise of the write strobe, and the single-cycle width of `done`. The bench scenarios are needed for the rest: data surviving a round trip through a memory model, exact pulse counts and `done` latency, the measured width of the write window, and requests ignored while busy.

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl #(
  parameter int AW      = 15,
  parameter int DW      = 8,
  parameter int CLK_NS  = 10,
  parameter int T_WC_NS = 10,
  parameter int T_AW_NS = 8,
  parameter int T_DS_NS = 5,
  parameter int T_AA_NS = 10,
  parameter int T_OE_NS = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  inout  wire  [DW-1:0] mem_dq
);
  localparam int C_AW  = (T_AW_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_DS  = (T_DS_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_WC  = (T_WC_NS + CLK_NS - 1) / CLK_NS - 2;
  localparam int C_AA  = (T_AA_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_OE  = (T_OE_NS + CLK_NS - 1) / CLK_NS;
  localparam int W1    = (C_AW > C_DS) ? C_AW : C_DS;
  localparam int W2    = (W1 > C_WC) ? W1 : C_WC;
  localparam int WE_CYC = (W2 > 1) ? W2 : 1;
  localparam int R1C   = (C_AA > C_OE) ? C_AA : C_OE;
  localparam int RD_CYC = (R1C > 1) ? R1C : 1;
  localparam int CMAX  = (WE_CYC > RD_CYC) ? WE_CYC : RD_CYC;
  localparam int CW    = (CMAX > 1) ? $clog2(CMAX) : 1;

  typedef enum logic [2:0] {S_IDLE, S_WSET, S_WPUL, S_WHLD, S_RACC} st_t;

  st_t           st, nst;
  logic [CW-1:0] cnt;
  logic [DW-1:0] wd_q;
  logic          drv;

  assign mem_dq = drv ? wd_q : {DW{1'bz}};

  always_comb begin
    nst = st;
    case (st)
      S_IDLE: if (req) nst = req_wr ? S_WSET : S_RACC;
      S_WSET: nst = S_WPUL;
      S_WPUL: if (cnt == '0) nst = S_WHLD;
      S_WHLD: nst = S_IDLE;
      S_RACC: if (cnt == '0) nst = S_IDLE;
      default: nst = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      mem_ce_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_oe_n <= 1'b1;
      drv      <= 1'b0;
      done     <= 1'b0;
      mem_addr <= '0;
      wd_q     <= '0;
      rdata    <= '0;
    end else begin
      st       <= nst;
      mem_ce_n <= (nst == S_IDLE);
      mem_we_n <= (nst != S_WPUL);
      mem_oe_n <= (nst != S_RACC);
      drv      <= (nst == S_WSET) || (nst == S_WPUL) || (nst == S_WHLD);
      done     <= (st != S_IDLE) && (nst == S_IDLE);
      if (st == S_IDLE && req) begin
        mem_addr <= req_addr;
        wd_q     <= req_wdata;
      end
      if (nst != st)
        cnt <= (nst == S_WPUL) ? CW'(WE_CYC - 1) : CW'(RD_CYC - 1);
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
      if (st == S_RACC && cnt == '0)
        rdata <= mem_dq;
    end
  end

  p_bus_owner_r7: assert property (@(posedge clk) disable iff (rst)
    drv |-> (mem_oe_n && $past(mem_oe_n)));

  p_write_strobes_r4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n));

  p_read_strobes_r6: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n && !drv));

  p_hold_after_we_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(wd_q) && drv && !mem_ce_n));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_idle_deselect_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (mem_ce_n && mem_we_n && mem_oe_n));
endmodule

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;
  localparam int CLK_PERIOD = 5;
  localparam int EXP_WE = 2;  // max(ceil(8/5), ceil(5/5), ceil(10/5)-2, 1)
  localparam int EXP_RD = 2;  // max(ceil(10/5), ceil(5/5))

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        req_wr = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  rdata;
  logic        done;
  logic [14:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n;
  wire  [7:0]  mem_dq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2.0) clk = ~clk;

  sram_async_ctrl #(.CLK_NS(CLK_PERIOD)) dut_i (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .rdata(rdata), .done(done), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq(mem_dq)
  );

  logic [7:0] store [int];
  wire        m_drive  = !mem_ce_n && !mem_oe_n && mem_we_n;
  wire        wr_open  = !mem_ce_n && !mem_we_n;
  logic [7:0] m_rd;
  realtime    t_open, last_width;

  always_comb m_rd = store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : 8'h00;
  assign mem_dq = m_drive ? m_rd : 8'bz;

  always @(posedge wr_open) t_open = $realtime;
  always @(negedge wr_open) begin
    store[int'(mem_addr)] = mem_dq;
    last_width = $realtime - t_open;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [14:0] a, input logic [7:0] d, input bit poke);
    int lat = 1, we_low = 0;
    bit oe_bad = 0, ce_bad = 0, addr_bad = 0;
    @(negedge clk);
    req = 1; req_wr = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 0;
    while (!done && lat < 50) begin
      if (!mem_we_n) we_low++;
      if (!mem_oe_n) oe_bad = 1;
      if (mem_ce_n) ce_bad = 1;
      if (mem_addr != a) addr_bad = 1;
      if (poke && lat == 2) begin req = 1; req_wr = 1; req_addr = 15'h0002; req_wdata = 8'hEE; end
      else if (poke && lat == 3) begin req = 0; req_wr = 0; end
      @(negedge clk);
      lat++;
    end
    check(lat == EXP_WE + 3, "R8 write done latency", lat, EXP_WE + 3);
    check(we_low == EXP_WE, "R3 write strobe cycles", we_low, EXP_WE);
    check(last_width >= 8.0, "R3 write window ns", int'(last_width), 8);
    check(!oe_bad && !ce_bad, "R4 strobes during write", {oe_bad, ce_bad}, 0);
    check(!addr_bad, "R5 address stable", int'(addr_bad), 0);
    check(mem_ce_n, "R10 deselect after write", int'(mem_ce_n), 1);
    @(negedge clk);
    check(!done, "R8 done one cycle", int'(done), 0);
  endtask

  task automatic do_read(input logic [14:0] a, input logic [7:0] exp);
    int lat = 1, oe_low = 0;
    bit bad = 0;
    @(negedge clk);
    req = 1; req_wr = 0; req_addr = a;
    @(negedge clk);
    req = 0;
    while (!done && lat < 50) begin
      if (!mem_oe_n) oe_low++;
      if (mem_ce_n || !mem_we_n || mem_addr != a) bad = 1;
      @(negedge clk);
      lat++;
    end
    check(lat == EXP_RD + 1, "R8 read done latency", lat, EXP_RD + 1);
    check(oe_low == EXP_RD && !bad, "R6 read strobes", oe_low, EXP_RD);
    check(rdata == exp, "R2 read data", rdata, exp);
    @(negedge clk);
    check(!done, "R8 done one cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_we_n && mem_oe_n && !done, "R1 reset state",
          {mem_ce_n, mem_we_n, mem_oe_n, done}, 4'b1110);
    rst = 0;
    @(negedge clk);
    check(mem_ce_n && mem_we_n && mem_oe_n && !done, "R1 after reset",
          {mem_ce_n, mem_we_n, mem_oe_n, done}, 4'b1110);
  endtask

  task automatic t_corners();
    do_write(15'h0000, 8'h5A, 0);
    do_write(15'h7FFF, 8'hA5, 0);
    do_read(15'h0000, 8'h5A);
    do_read(15'h7FFF, 8'hA5);
  endtask

  task automatic t_read_then_write();
    do_read(15'h7FFF, 8'hA5);
    do_write(15'h0123, 8'h3C, 0);
    do_read(15'h0123, 8'h3C);
  endtask

  task automatic t_busy_ignored();
    int extra = 0;
    do_write(15'h0002, 8'h77, 0);
    do_write(15'h1234, 8'h11, 1);
    repeat (8) begin
      @(negedge clk);
      if (done) extra++;
    end
    check(extra == 0, "R9 no extra done", extra, 0);
    do_read(15'h0002, 8'h77);
    do_read(15'h1234, 8'h11);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_corners();
        t_read_then_write();
        t_busy_ignored();
      end
      begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule